// File: doc/BRIEF.md
# Slow-Clock Timer with Synchronized Register Access

An 8-bit counter that advances on a slow, free-running timer clock, such as a watch-crystal domain. A processor reaches it from a much faster I/O clock. Writes to the control, counter-load and compare registers land first in holding registers in the I/O domain. Each holding register then crosses to the timer domain through a toggle handshake. While that transfer is in flight, a per-register busy flag is set.

The processor never samples the running counter directly. It reads a snapshot register in the I/O domain, which is reloaded once for each rising edge of the timer clock. When the counter equals the compare value on a timer edge, three things happen:
- A toggle event is raised in the timer domain, synchronized into the I/O domain, and sets a sticky interrupt flag.
- A wake request is driven for the following timer cycle, for use by a sleep controller.
- The compare output pin toggles on the timer clock, if that feature is enabled.

The I/O clock may be stopped during sleep and later restarted. The snapshot then keeps its pre-sleep value until the next timer edge is seen.

Top module: `async_timer8`

## Requirements
- R1: An active-low asynchronous reset clears the control, compare, counter and snapshot registers, all busy flags, the interrupt flag, the wake request and the compare output.
- R2: The register select codes are: 0 control, 1 counter (a write loads the counter, a read returns the snapshot), 2 compare, 3 status. An accepted write to selects 0, 1 or 2 sets that register's busy flag on the next I/O edge. The flag clears only after the timer domain has taken the value. Control and compare read back the written value.
- R3: A write to a register whose busy flag is set is ignored, and its holding register keeps the earlier value. Writes to select 3 do nothing.
- R4: While control bit 0 (run) is set, the counter increments on each timer edge and wraps from 255 to 0. A counter load takes effect on the timer edge that completes the transfer.
- R5: A compare match is a timer edge on which the counter equals the compare value. Three I/O cycles after the match toggle leaves the timer domain, the interrupt flag is set. Once the flag is visible, the snapshot shows the compare value plus one (mod 256).
- R6: The snapshot is reloaded only for rising timer edges. After the I/O clock stops and restarts, it keeps its pre-stop value until the next rising timer edge.
- R7: A one-cycle irq_clr pulse clears the interrupt flag. If a set and a clear fall in the same I/O cycle, the set wins.
- R8: wake_req is high for exactly the timer cycle that follows a compare match.
- R9: When control bit 1 is set, cmp_out toggles on each compare match. It changes only on the timer clock.
- R10: For one timer cycle after a match, the compare logic re-arms. A match condition on the very next timer edge is not reported; with a stopped counter equal to compare, matches fire on every other edge.
- R11: A status read returns the interrupt flag in bit 3 and the busy flags in bits 2 to 0 (compare, counter, control), with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | Processor I/O clock |
| clk_tmr | input | 1 | Slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Read source select |
| rd_data | output | WIDTH | Read data (combinational) |
| irq_clr | input | 1 | Clear the interrupt flag |
| busy | output | 3 | Update-busy flags: compare, counter, control |
| irq_flag | output | 1 | Sticky compare interrupt flag (I/O domain) |
| wake_req | output | 1 | Wake request (timer domain) |
| cmp_out | output | 1 | Compare output pin (timer domain) |

## Verification
The interrupt flag has two I/O-domain actions that can meet in one cycle: the synchronized set from a compare match and the software clear. The bench provokes the collision by holding irq_clr high through a whole run up to a match. It expects the flag to be seen high for exactly one I/O cycle, because the set wins its cycle and the next clear removes it. A second overlap lives in the timer domain, where a counter load and an increment compete on the same edge. The bench judges it through the snapshot values at each match.

// File: rtl/async_timer8.sv
module async_timer8 #(
  parameter int WIDTH = 8
) (
  input  logic             clk_io,
  input  logic             clk_tmr,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic             irq_clr,
  output logic [2:0]       busy,
  output logic             irq_flag,
  output logic             wake_req,
  output logic             cmp_out
);

  localparam int NREG = 3;

  logic [WIDTH-1:0] hold_q [NREG];
  logic [NREG-1:0]  req_t, ack_m, ack_s;
  logic [NREG-1:0]  wr_ok;
  logic [WIDTH-1:0] snap_q;
  logic             ev_m, ev_s, ev_d, ev_set;
  logic             tk_m, tk_s, tk_d, tk_rise;

  logic [NREG-1:0]  rq_m, rq_s, ack_t, upd;
  logic [WIDTH-1:0] ctrl_t, cnt_t, cmp_t;
  logic             fire, rearm_q, ev_t;

  assign busy    = req_t ^ ack_s;
  assign ev_set  = ev_s ^ ev_d;
  assign tk_rise = tk_s & ~tk_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_ok[i] = wr_en && (wr_sel == 2'(i)) && !busy[i];

    always_ff @(posedge clk_io or negedge rst_n)
      if (!rst_n) begin
        hold_q[i] <= '0;
        req_t[i]  <= 1'b0;
      end else if (wr_ok[i]) begin
        hold_q[i] <= wr_data;
        req_t[i]  <= ~req_t[i];
      end
  end

  always_ff @(posedge clk_io or negedge rst_n)
    if (!rst_n) begin
      ack_m    <= '0;
      ack_s    <= '0;
      ev_m     <= 1'b0;
      ev_s     <= 1'b0;
      ev_d     <= 1'b0;
      irq_flag <= 1'b0;
      tk_m     <= 1'b0;
      tk_s     <= 1'b0;
      tk_d     <= 1'b0;
      snap_q   <= '0;
    end else begin
      ack_m    <= ack_t;
      ack_s    <= ack_m;
      ev_m     <= ev_t;
      ev_s     <= ev_m;
      ev_d     <= ev_s;
      irq_flag <= ev_set | (irq_flag & ~irq_clr);
      tk_m     <= clk_tmr;
      tk_s     <= tk_m;
      tk_d     <= tk_s;
      if (tk_rise) snap_q <= cnt_t;
    end

  always_comb
    case (rd_sel)
      2'd0:    rd_data = hold_q[0];
      2'd1:    rd_data = snap_q;
      2'd2:    rd_data = hold_q[2];
      default: rd_data = {{(WIDTH-4){1'b0}}, irq_flag, busy};
    endcase

  assign upd  = rq_s ^ ack_t;
  assign fire = (cnt_t == cmp_t) && !rearm_q;

  always_ff @(posedge clk_tmr or negedge rst_n)
    if (!rst_n) begin
      rq_m     <= '0;
      rq_s     <= '0;
      ack_t    <= '0;
      ctrl_t   <= '0;
      cmp_t    <= '0;
      cnt_t    <= '0;
      rearm_q  <= 1'b0;
      ev_t     <= 1'b0;
      wake_req <= 1'b0;
      cmp_out  <= 1'b0;
    end else begin
      rq_m     <= req_t;
      rq_s     <= rq_m;
      ack_t    <= rq_s;
      if (upd[0]) ctrl_t <= hold_q[0];
      if (upd[2]) cmp_t  <= hold_q[2];
      if (upd[1])         cnt_t <= hold_q[1];
      else if (ctrl_t[0]) cnt_t <= cnt_t + 1'b1;
      rearm_q  <= fire;
      ev_t     <= ev_t ^ fire;
      wake_req <= fire;
      cmp_out  <= cmp_out ^ (fire & ctrl_t[1]);
    end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk_io) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !busy[2]) |=> busy[2]); // R2
  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk_io) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && busy[2]) |=> $stable(hold_q[2])); // R3
  AST_SET_WINS: assert property (@(posedge clk_io) disable iff (!rst_n)
    ev_set |=> irq_flag); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk_io) disable iff (!rst_n)
    (irq_clr && !ev_set) |=> !irq_flag); // R7
  AST_WRAP: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (ctrl_t[0] && !upd[1] && cnt_t == {WIDTH{1'b1}}) |=> cnt_t == '0); // R4
  AST_REARM_GAP: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    fire |=> !fire); // R10
  AST_WAKE_AFTER_MATCH: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    fire |=> wake_req); // R8

endmodule

// File: tb/async_timer8_tb.sv
`timescale 1ns/1ps
module async_timer8_tb;
  localparam int IO_PERIOD = 10;
  localparam int TMR_HALF  = 83;
  localparam int NV = 4;
  localparam logic [7:0] V_LOAD [NV] = '{8'd10, 8'd250, 8'd0,   8'd77};
  localparam logic [7:0] V_CMP  [NV] = '{8'd20, 8'd3,   8'd255, 8'd78};
  localparam logic [7:0] V_CTRL [NV] = '{8'd3,  8'd3,   8'd1,   8'd3};

  logic clk_io = 0, clk_tmr = 0, rst_n = 0, io_on = 1;
  logic wr_en = 0, irq_clr = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] busy;
  logic irq_flag, wake_req, cmp_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(IO_PERIOD/2) clk_io = io_on ? ~clk_io : 1'b0;
  initial begin #3; forever #(TMR_HALF) clk_tmr = ~clk_tmr; end

  async_timer8 #(.WIDTH(8)) u_dut (
    .clk_io(clk_io), .clk_tmr(clk_tmr), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_clr(irq_clr), .busy(busy), .irq_flag(irq_flag),
    .wake_req(wake_req), .cmp_out(cmp_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk_io); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk_io); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic idle(input string tag);
    int n = 0;
    while (busy != 0 && n < 3000) begin @(negedge clk_io); n++; end
    chk({tag, " busy clears"}, busy, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk_io); irq_clr = 1; @(negedge clk_io); irq_clr = 0;
  endtask

  initial begin
    #(IO_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, s0;
    logic co;
    int n, hi, pairs;
    logic prev;

    repeat (3) @(posedge clk_tmr);
    #5 rst_n = 1;
    @(negedge clk_io);
    rd(2'd3, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 snapshot", v, 0);
    rd(2'd0, v); chk("R1 control", v, 0);
    rd(2'd2, v); chk("R1 compare", v, 0);
    chk("R1 wake", wake_req, 0);
    chk("R1 cmp_out", cmp_out, 0);

    wr(2'd2, 8'd5);
    chk("R2 busy set", busy[2], 1);
    rd(2'd3, v); chk("R11 status busy bit", v[2:0], 3'b100);
    wr(2'd2, 8'd9);
    idle("R2");
    rd(2'd2, v); chk("R3 ignored write", v, 5);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R3 status write ignored", v[2:0], 0);
    wr(2'd0, 8'd2); idle("R2");
    rd(2'd0, v); chk("R2 control readback", v, 2);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'd0); idle("R2");
      wr(2'd1, V_LOAD[i]); idle("R2");
      wr(2'd2, V_CMP[i]); idle("R2");
      repeat (3) @(negedge clk_tmr);
      pulse_clr();
      chk("R7 cleared", irq_flag, 0);
      co = cmp_out;
      wr(2'd0, V_CTRL[i]);
      n = 0;
      while (!irq_flag && n < 6000) begin @(negedge clk_io); n++; end
      chk("R5 flag seen", irq_flag, 1);
      repeat (4) @(negedge clk_io);
      rd(2'd1, v);
      chk("R5 R4 snapshot past compare", v, 8'(V_CMP[i] + 8'd1));
      rd(2'd3, v); chk("R11 status flag bit", v[3], 1);
      chk("R8 wake after match", wake_req, 1);
      chk("R9 cmp_out", cmp_out, co ^ V_CTRL[i][1]);
    end

    wr(2'd0, 8'd0); idle("R2");
    wr(2'd1, 8'd40); idle("R2");
    wr(2'd2, 8'd40); idle("R2");
    repeat (3) @(negedge clk_tmr);
    hi = 0; pairs = 0; prev = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_tmr);
      if (wake_req) hi++;
      if (wake_req && prev) pairs++;
      prev = wake_req;
    end
    chk("R10 every other edge", hi, 4);
    chk("R10 no back-to-back", pairs, 0);

    wr(2'd2, 8'd60); idle("R2");
    repeat (3) @(negedge clk_tmr);
    pulse_clr();
    @(negedge clk_io); irq_clr = 1;
    wr(2'd0, 8'd1);
    hi = 0;
    for (int k = 0; k < 40 * 17; k++) begin
      @(negedge clk_io);
      if (irq_flag) hi++;
    end
    irq_clr = 0;
    chk("R7 set beats clear", hi, 1);

    wr(2'd2, 8'd200); idle("R2");
    repeat (3) @(negedge clk_tmr);
    #20; rd(2'd1, s0);
    io_on = 0;
    repeat (4) @(negedge clk_tmr);
    #20 io_on = 1;
    repeat (3) @(posedge clk_io);
    #1; rd(2'd1, v); chk("R6 held after restart", v, s0);
    @(posedge clk_tmr);
    repeat (5) @(posedge clk_io);
    #1; rd(2'd1, v); chk("R6 refreshed on edge", v, 8'(s0 + 8'd5));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule